// File: doc/BRIEF.md
# CAM Control Port Decoder

This block sits at the access port of a content-addressable memory. It takes a 12-bit shared address/control bus and three active-low strobes: an address strobe, a write strobe and a validity line. It turns each sampled cycle into one of two things. The first is a random read or write for the memory array. The second is a decoded command for the rest of the device. With the address strobe low, the bus is an entry address and the validity line carries the entry's valid bit. With the address strobe high and the write strobe low, the cycle is a command cycle.

A two-bit configuration field picks the source of the command code. In hardware control, the code comes from the low nine lines of the shared bus. In software control, it comes from the low nine bits of a 32-bit data bus, and bit 12 of that bus is captured into a flag of the instruction register. Random read and write cycles work the same way in both control modes.

Every result is registered. Strobes are single-cycle pulses that appear after the clock edge where the stimulus was sampled. The validity line is split into an input, an output and an output enable, so that the pad can be built outside the block.

Top module: `cam_port_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, all pulse outputs, `vb_oe`, `mem_addr`, `mem_wvalid`, `cmd_op`, `cmd_mask`, `cmd_sel` and `ir_flag` become 0 after that edge, and `vb_out` is 1.
- R2: Hardware control is selected when `cfg_mode` is 2'b00. Any other value (01, 10 or 11) selects software control.
- R3: A cycle with `av_n`=0 and `w_n`=0 gives a one-cycle `mem_wr` pulse after the edge. `mem_addr` takes the bus value and `mem_wvalid` takes the inverse of `vb_in` (`vb_in` low means valid, so 1 is stored).
- R4: A cycle with `av_n`=0 and `w_n`=1 gives a one-cycle `mem_rd` pulse after the edge, with `mem_addr` set to the bus value. In that same cycle `vb_oe` is 1 and `vb_out` is the inverse of `mem_vld_in` (0 for a valid entry, 1 for an empty one).
- R5: In every cycle that does not follow a read, `vb_oe` is 0 and `vb_out` is 1. `mem_addr` changes only on access cycles and `mem_wvalid` changes only on writes.
- R6: A cycle with `av_n`=1 and `w_n`=0 is a command cycle. In hardware control, its code is `ac_bus[8:0]`, and bus bits 11..9 are ignored. A recognised code gives a one-cycle `cmd_vld` pulse together with `cmd_op`, `cmd_mask` and `cmd_sel`. Outside a `cmd_vld` cycle those three outputs are 0.
- R7: In software control, the code of a command cycle is `dq[8:0]` and `ac_bus` is ignored. `ir_flag` takes `dq[12]` on every software command cycle and holds it until the next one.
- R8: Hardware command cycles and access cycles leave `ir_flag` unchanged.
- R9: The code is split into an opcode in bits 5..0 and a mask select in bits 8..6. The opcode values map to `cmd_op` as follows:
  - 0x00 no-op gives 0.
  - 0x01 compare gives 1.
  - 0x02 write at address register gives 2.
  - 0x03 read at address register gives 3.
  - 0x04 mark valid gives 4.
  - 0x05 mark empty gives 5.
  - 0x06 load address register gives 6.
  - 0x20..0x2F select register gives 7, with `cmd_sel` set to opcode bits 3..0.
- R10: A command cycle whose code is not recognised gives a one-cycle `cmd_err` pulse, with `cmd_vld` staying 0 and `cmd_op` staying 0.
- R11: A cycle with `av_n`=1 and `w_n`=1 is idle. No pulse follows it.
- R12: A nonzero mask select is recognised only with compare or write-at-address-register, and only with values 1 or 2, which appear on `cmd_mask`. Mask select values 3..7, and any nonzero mask select with another opcode, make the code unrecognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Control mode field, 00 = hardware control |
| av_n | input | 1 | Address strobe, low = random access cycle |
| w_n | input | 1 | Write strobe, low = write / command |
| ac_bus | input | 12 | Shared address/control bus |
| dq | input | 32 | Data bus, carries the code in software control |
| vb_in | input | 1 | Validity line as driven from outside |
| vb_out | output | 1 | Validity line driven by the block (low = valid) |
| vb_oe | output | 1 | Output enable for the validity line |
| mem_vld_in | input | 1 | Valid bit of the entry at `mem_addr`, from the memory |
| mem_wr | output | 1 | Write pulse to the memory |
| mem_rd | output | 1 | Read pulse to the memory |
| mem_addr | output | 12 | Entry address to the memory |
| mem_wvalid | output | 1 | Valid bit to store (1 = valid) |
| cmd_vld | output | 1 | Decoded command pulse |
| cmd_err | output | 1 | Unrecognised code pulse |
| cmd_op | output | 3 | Decoded operation |
| cmd_mask | output | 2 | Mask register select of the command |
| cmd_sel | output | 4 | Register index of a select command |
| ir_flag | output | 1 | Instruction register flag (data bit 12) |

## Verification
Every result is due exactly one rising edge after the cycle that caused it. The pulses, the decoded fields, the address, the flag and the read-back on the validity line all follow this rule. The validity read-back also goes through the bench's own memory model, which answers combinationally from `mem_addr` in that same cycle. The bench drives each cycle's inputs on the falling edge and waits for the next rising edge. It then samples one time unit later and compares every output against a behavioural model that has been advanced by that one cycle. A write followed at once by a read of the same entry checks that a freshly stored validity bit is seen in the very next cycle.

// File: rtl/cam_port_pkg.sv
// Shared operation type and code constants for the CAM control port decoder.
// Assumes a 6-bit opcode field below a mask-select field.
package cam_port_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_CMP  = 3'd1,
        OP_WRA  = 3'd2,
        OP_RDA  = 3'd3,
        OP_SETV = 3'd4,
        OP_SETE = 3'd5,
        OP_LDA  = 3'd6,
        OP_SEL  = 3'd7
    } cmd_op_e;

    localparam logic [5:0] OPC_NOP  = 6'h00;
    localparam logic [5:0] OPC_CMP  = 6'h01;
    localparam logic [5:0] OPC_WRA  = 6'h02;
    localparam logic [5:0] OPC_RDA  = 6'h03;
    localparam logic [5:0] OPC_SETV = 6'h04;
    localparam logic [5:0] OPC_SETE = 6'h05;
    localparam logic [5:0] OPC_LDA  = 6'h06;
    // Select-register opcodes: top two opcode bits equal this prefix.
    localparam logic [1:0] SEL_PREFIX = 2'b10;

endpackage

// File: rtl/cam_code_decode.sv
// Combinational decoder from a 9-bit control code to an operation.
// Assumes: code = {mask select, opcode}; masks are valid only with compare
// and write-at-address-register, and only for select values below NUM_MASKS.
module cam_code_decode
    import cam_port_pkg::*;
#(
    parameter int OPC_W     = 6,
    parameter int MSEL_W    = 3,
    parameter int SEL_W     = 4,
    parameter int NUM_MASKS = 3,
    localparam int CODE_W   = OPC_W + MSEL_W,
    localparam int MASK_W   = $clog2(NUM_MASKS)
) (
    input  logic [CODE_W-1:0] code,
    output logic              ok,
    output cmd_op_e           op,
    output logic [MASK_W-1:0] mask,
    output logic [SEL_W-1:0]  sel
);

    logic [OPC_W-1:0]  opc;
    logic [MSEL_W-1:0] msel;

    assign opc  = code[OPC_W-1:0];
    assign msel = code[CODE_W-1:OPC_W];

    // Purpose: classify the opcode and check its mask select.
    always_comb begin
        ok   = 1'b0;
        op   = OP_NOP;
        mask = '0;
        sel  = '0;
        if (opc[OPC_W-1:SEL_W] == SEL_PREFIX) begin
            if (msel == '0) begin
                ok  = 1'b1;
                op  = OP_SEL;
                sel = opc[SEL_W-1:0];
            end
        end else begin
            case (opc)
                OPC_NOP:  if (msel == '0) begin ok = 1'b1; op = OP_NOP;  end
                OPC_RDA:  if (msel == '0) begin ok = 1'b1; op = OP_RDA;  end
                OPC_SETV: if (msel == '0) begin ok = 1'b1; op = OP_SETV; end
                OPC_SETE: if (msel == '0) begin ok = 1'b1; op = OP_SETE; end
                OPC_LDA:  if (msel == '0) begin ok = 1'b1; op = OP_LDA;  end
                OPC_CMP: if (int'(msel) < NUM_MASKS) begin
                    ok   = 1'b1;
                    op   = OP_CMP;
                    mask = msel[MASK_W-1:0];
                end
                OPC_WRA: if (int'(msel) < NUM_MASKS) begin
                    ok   = 1'b1;
                    op   = OP_WRA;
                    mask = msel[MASK_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cam_cmd_source.sv
// Picks the control code source (pins or data bus) and holds the
// instruction register flag. Assumes cfg_mode all-zero means hardware
// control; a command cycle is address strobe high with write strobe low.
module cam_cmd_source #(
    parameter int MODE_W = 2,
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              av_n,
    input  logic              w_n,
    input  logic [CODE_W-1:0] pin_code,
    input  logic [CODE_W-1:0] bus_code,
    input  logic              bus_flag,
    output logic              cmd_cycle,
    output logic [CODE_W-1:0] code,
    output logic              ir_flag
);

    logic hw_mode;

    assign hw_mode   = (cfg_mode == '0);
    assign cmd_cycle = av_n && !w_n;
    assign code      = hw_mode ? pin_code : bus_code;

    // Purpose: load the instruction register flag on software command cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_flag <= 1'b0;
        end else if (cmd_cycle && !hw_mode) begin
            ir_flag <= bus_flag;
        end
    end

    p_hw_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode || !cmd_cycle) |=> $stable(ir_flag))
        else $error("p_hw_keeps_flag_r8");

    p_sw_loads_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_mode && cmd_cycle) |=> (ir_flag == $past(bus_flag)))
        else $error("p_sw_loads_flag_r7");

endmodule

// File: rtl/cam_access_ctl.sv
// Random read/write path: registers the entry address, the validity bit
// to store, the access pulses and the validity line output enable.
// Assumes the memory answers mem_vld_in combinationally from mem_addr.
module cam_access_ctl #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_n,
    input  logic              w_n,
    input  logic [ADDR_W-1:0] ac_bus,
    input  logic              vb_in,
    input  logic              mem_vld_in,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wvalid,
    output logic              vb_oe,
    output logic              vb_out
);

    logic wr_cyc;
    logic rd_cyc;

    assign wr_cyc = !av_n && !w_n;
    assign rd_cyc = !av_n && w_n;

    // Purpose: register access pulses, address, stored validity and drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr     <= 1'b0;
            mem_rd     <= 1'b0;
            mem_addr   <= '0;
            mem_wvalid <= 1'b0;
            vb_oe      <= 1'b0;
        end else begin
            mem_wr <= wr_cyc;
            mem_rd <= rd_cyc;
            vb_oe  <= rd_cyc;
            if (!av_n) begin
                mem_addr <= ac_bus;
            end
            if (wr_cyc) begin
                mem_wvalid <= !vb_in;
            end
        end
    end

    // Purpose: drive the active-low validity of the read entry, idle high.
    assign vb_out = vb_oe ? !mem_vld_in : 1'b1;

    p_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cyc |=> (mem_wr && !mem_rd && mem_addr == $past(ac_bus)))
        else $error("p_write_pulse_r3");

    p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cyc |=> (mem_rd && vb_oe && !mem_wr))
        else $error("p_read_drive_r4");

    p_oe_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cyc |=> (!vb_oe && vb_out))
        else $error("p_oe_released_r5");

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        av_n |=> $stable(mem_addr))
        else $error("p_addr_held_r5");

endmodule

// File: rtl/cam_port_decoder.sv
// Top of the CAM control port decoder. Splits each sampled cycle into a
// random access (address strobe low) or a command (address strobe high,
// write strobe low), decodes the code from pins or data bus depending on
// the control mode, and registers all results as one-cycle pulses.
// Assumes synchronous active-low reset and a single clock.
module cam_port_decoder
    import cam_port_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int MODE_W    = 2,
    parameter int OPC_W     = 6,
    parameter int MSEL_W    = 3,
    parameter int SEL_W     = 4,
    parameter int NUM_MASKS = 3,
    parameter int FLAG_BIT  = 12,
    localparam int CODE_W   = OPC_W + MSEL_W,
    localparam int MASK_W   = $clog2(NUM_MASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              av_n,
    input  logic              w_n,
    input  logic [ADDR_W-1:0] ac_bus,
    input  logic [DATA_W-1:0] dq,
    input  logic              vb_in,
    output logic              vb_out,
    output logic              vb_oe,
    input  logic              mem_vld_in,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wvalid,
    output logic              cmd_vld,
    output logic              cmd_err,
    output logic [2:0]        cmd_op,
    output logic [MASK_W-1:0] cmd_mask,
    output logic [SEL_W-1:0]  cmd_sel,
    output logic              ir_flag
);

    logic              cmd_cycle;
    logic [CODE_W-1:0] code;
    logic              dec_ok;
    cmd_op_e           dec_op;
    logic [MASK_W-1:0] dec_mask;
    logic [SEL_W-1:0]  dec_sel;
    logic              dq_unused;

    // Data bus bits that carry neither the code nor the flag.
    assign dq_unused = ^{dq[DATA_W-1:FLAG_BIT+1], dq[FLAG_BIT-1:CODE_W]};

    cam_cmd_source #(
        .MODE_W (MODE_W),
        .CODE_W (CODE_W)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .av_n      (av_n),
        .w_n       (w_n),
        .pin_code  (ac_bus[CODE_W-1:0]),
        .bus_code  (dq[CODE_W-1:0]),
        .bus_flag  (dq[FLAG_BIT]),
        .cmd_cycle (cmd_cycle),
        .code      (code),
        .ir_flag   (ir_flag)
    );

    cam_code_decode #(
        .OPC_W     (OPC_W),
        .MSEL_W    (MSEL_W),
        .SEL_W     (SEL_W),
        .NUM_MASKS (NUM_MASKS)
    ) u_dec (
        .code (code),
        .ok   (dec_ok),
        .op   (dec_op),
        .mask (dec_mask),
        .sel  (dec_sel)
    );

    cam_access_ctl #(
        .ADDR_W (ADDR_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .av_n       (av_n),
        .w_n        (w_n),
        .ac_bus     (ac_bus),
        .vb_in      (vb_in),
        .mem_vld_in (mem_vld_in),
        .mem_wr     (mem_wr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_wvalid (mem_wvalid),
        .vb_oe      (vb_oe),
        .vb_out     (vb_out)
    );

    // Purpose: register the decoded command or the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld  <= 1'b0;
            cmd_err  <= 1'b0;
            cmd_op   <= 3'd0;
            cmd_mask <= '0;
            cmd_sel  <= '0;
        end else begin
            cmd_vld  <= cmd_cycle && dec_ok;
            cmd_err  <= cmd_cycle && !dec_ok;
            cmd_op   <= (cmd_cycle && dec_ok) ? dec_op   : OP_NOP;
            cmd_mask <= (cmd_cycle && dec_ok) ? dec_mask : '0;
            cmd_sel  <= (cmd_cycle && dec_ok) ? dec_sel  : '0;
        end
    end

    p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_vld, cmd_err, mem_wr, mem_rd}))
        else $error("p_one_result_r6");

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (av_n && w_n) |=> !(cmd_vld || cmd_err || mem_wr || mem_rd))
        else $error("p_idle_quiet_r11");

    p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cycle && !dec_ok) |=> (cmd_err && cmd_op == 3'd0))
        else $error("p_bad_code_r10");

    p_mask_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_mask != '0) |-> (cmd_op == OP_CMP || cmd_op == OP_WRA))
        else $error("p_mask_gated_r12");

endmodule

// File: tb/cam_port_decoder_tb.sv
`timescale 1ns/1ps
module cam_port_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic        av_n, w_n, vb_in;
    logic [11:0] ac_bus;
    logic [31:0] dq;
    logic        vb_out, vb_oe, mem_vld_in;
    logic        mem_wr, mem_rd, mem_wvalid;
    logic [11:0] mem_addr;
    logic        cmd_vld, cmd_err, ir_flag;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_mask;
    logic [3:0]  cmd_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Bench memory: validity bits, 1 = valid.
    bit mem_arr [0:4095];
    // Reference model state.
    bit ref_arr [0:4095];
    int e_addr, e_wval, e_flag;

    always #2.5 clk = ~clk;

    cam_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .av_n(av_n), .w_n(w_n),
        .ac_bus(ac_bus), .dq(dq), .vb_in(vb_in), .vb_out(vb_out), .vb_oe(vb_oe),
        .mem_vld_in(mem_vld_in), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wvalid(mem_wvalid), .cmd_vld(cmd_vld),
        .cmd_err(cmd_err), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
        .cmd_sel(cmd_sel), .ir_flag(ir_flag)
    );

    assign mem_vld_in = mem_arr[mem_addr];

    always @(posedge clk) begin
        if (mem_wr) mem_arr[mem_addr] <= mem_wvalid;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural decode of a 9-bit code from the requirement table.
    function automatic void ref_decode(input int c, output bit ok, output int op,
                                       output int mask, output int sel);
        int o = c % 64;
        int m = c / 64;
        ok = 0; op = 0; mask = 0; sel = 0;
        if (o >= 32 && o <= 47) begin
            if (m == 0) begin ok = 1; op = 7; sel = o - 32; end
        end else if (o <= 6) begin
            if (m == 0) begin
                ok = 1; op = o;
            end else if ((o == 1 || o == 2) && m <= 2) begin
                ok = 1; op = o; mask = m;
            end
        end
    endfunction

    // One clock cycle: drive, advance the model, compare all outputs.
    task automatic step(input string req, input bit rst, input int mode, input bit av,
                        input bit w, input bit vb, input int ac, input int d);
        bit ok, is_wr, is_rd, is_cmd, hw;
        int op, mask, sel, code;
        int x_vld, x_err, x_op, x_mask, x_sel, x_vbo;
        @(negedge clk);
        rst_n = !rst; cfg_mode = mode[1:0]; av_n = av; w_n = w; vb_in = vb;
        ac_bus = ac[11:0]; dq = d;
        @(posedge clk);
        #1;
        is_wr = !av && !w; is_rd = !av && w; is_cmd = av && !w;
        hw = (mode == 0);
        code = hw ? (ac % 512) : (d % 512);
        ref_decode(code, ok, op, mask, sel);
        x_vld = 0; x_err = 0; x_op = 0; x_mask = 0; x_sel = 0; x_vbo = 1;
        if (rst) begin
            is_wr = 0; is_rd = 0;
            e_addr = 0; e_wval = 0; e_flag = 0;
        end else begin
            if (!av) e_addr = ac % 4096;
            if (is_wr) begin e_wval = !vb; ref_arr[e_addr] = !vb; end
            if (is_rd) x_vbo = !ref_arr[e_addr];
            if (is_cmd) begin
                if (ok) begin x_vld = 1; x_op = op; x_mask = mask; x_sel = sel; end
                else x_err = 1;
                if (!hw) e_flag = (d >> 12) & 1;
            end
        end
        chk(req, "mem_wr", mem_wr, is_wr);
        chk(req, "mem_rd", mem_rd, is_rd);
        chk(req, "vb_oe", vb_oe, is_rd);
        chk(req, "vb_out", vb_out, x_vbo);
        chk(req, "mem_addr", mem_addr, e_addr);
        chk(req, "mem_wvalid", mem_wvalid, e_wval);
        chk(req, "cmd_vld", cmd_vld, x_vld);
        chk(req, "cmd_err", cmd_err, x_err);
        chk(req, "cmd_op", cmd_op, x_op);
        chk(req, "cmd_mask", cmd_mask, x_mask);
        chk(req, "cmd_sel", cmd_sel, x_sel);
        chk(req, "ir_flag", ir_flag, e_flag);
    endtask

    // Hardware-mode command helper.
    task automatic hwc(input string req, input int c);
        step(req, 0, 0, 1, 0, 1, c, 32'h0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin mem_arr[i] = 0; ref_arr[i] = 0; end
        e_addr = 0; e_wval = 0; e_flag = 0;
        rst_n = 0; cfg_mode = 0; av_n = 1; w_n = 1; vb_in = 1; ac_bus = 0; dq = 0;
        // R1: reset state
        step("R1", 1, 0, 1, 1, 1, 0, 0);
        step("R1", 1, 0, 0, 0, 0, 12'h055, 0);
        // R3 / R4: writes and reads in hardware control
        step("R3", 0, 0, 0, 0, 0, 12'h005, 0);
        step("R3", 0, 0, 0, 0, 1, 12'h007, 0);
        step("R4", 0, 0, 0, 1, 1, 12'h005, 0);
        step("R4", 0, 0, 0, 1, 0, 12'h007, 0);
        step("R4", 0, 0, 0, 1, 1, 12'hFFF, 0);
        // write then immediate read of same entry
        step("R3", 0, 0, 0, 0, 0, 12'hABC, 0);
        step("R4", 0, 0, 0, 1, 1, 12'hABC, 0);
        step("R3", 0, 0, 0, 0, 1, 12'hABC, 0);
        step("R4", 0, 0, 0, 1, 1, 12'hABC, 0);
        // R5 / R11: idle cycles keep address and release the line
        step("R11", 0, 0, 1, 1, 0, 12'h123, 32'h1001);
        step("R5", 0, 0, 1, 1, 1, 12'h456, 0);
        // R6 / R9: every opcode in hardware control
        hwc("R9", 9'h000); hwc("R9", 9'h001); hwc("R9", 9'h002);
        hwc("R9", 9'h003); hwc("R9", 9'h004); hwc("R9", 9'h005);
        hwc("R9", 9'h006); hwc("R9", 9'h020); hwc("R9", 9'h02A);
        hwc("R9", 9'h02F);
        hwc("R6", 12'hE01);           // upper bus bits ignored
        hwc("R6", 12'h803);
        // R12: mask selects
        hwc("R12", 9'h041); hwc("R12", 9'h082); hwc("R12", 9'h0C1);
        hwc("R12", 9'h1C2); hwc("R12", 9'h043); hwc("R12", 9'h040);
        hwc("R12", 9'h06A);
        // R10: unrecognised codes
        hwc("R10", 9'h007); hwc("R10", 9'h03F); hwc("R10", 9'h010);
        hwc("R10", 9'h030); hwc("R10", 9'h1FF);
        // R7: software control, ac_bus carries a bad code and is ignored
        step("R7", 0, 1, 1, 0, 1, 12'h1FF, 32'h0000_1001);
        step("R7", 0, 1, 1, 1, 1, 12'h1FF, 32'h0000_0000);
        step("R7", 0, 2, 1, 0, 1, 12'h001, 32'hFFFF_E007);
        step("R2", 0, 3, 1, 0, 1, 12'h000, 32'h0000_1082);
        step("R2", 0, 0, 1, 0, 1, 12'h000, 32'h0000_1082);
        // R8: hardware commands and accesses keep the flag
        step("R8", 0, 0, 1, 0, 1, 12'h003, 32'h0000_0000);
        step("R8", 0, 0, 0, 0, 0, 12'h010, 32'h0000_0000);
        step("R8", 0, 1, 0, 1, 1, 12'h010, 32'h0000_0000);
        step("R7", 0, 1, 1, 0, 1, 12'h000, 32'h0000_0025);
        step("R7", 0, 1, 1, 0, 1, 12'h000, 32'h0000_1000);
        // R3 / R4 in software control
        step("R3", 0, 2, 0, 0, 0, 12'h3C3, 32'h0000_0001);
        step("R4", 0, 2, 0, 1, 1, 12'h3C3, 32'h0000_0001);
        step("R4", 0, 2, 0, 1, 1, 12'h005, 32'h0000_0001);
        // R1: reset mid-run clears the flag and address
        step("R1", 1, 1, 1, 0, 1, 12'h001, 32'h0000_1001);
        step("R1", 0, 0, 1, 1, 1, 12'h000, 0);
        step("R4", 0, 0, 0, 1, 1, 12'h3C3, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule